// File: doc/BRIEF.md
# Sheep-and-Goats Bit Separator

This unit takes a data word and a mask word of the same width and reorders the data bits into two packed groups. The bits whose mask bit is 1 (the goats) are gathered at the least significant end of the result. The bits whose mask bit is 0 (the sheep) are gathered at the most significant end. Each group keeps the relative order its bits had in the data word. A chain of such passes, one per bit of the bit-index width, can realise any bit permutation, so a caller can use the unit as one stage of a permutation routine.

The datapath has two compress lanes that run side by side. Both see the data one bit per cycle, lowest bit first. One lane keeps the bits under mask 1 and the other keeps the bits under mask 0, and each packs its kept bits upward from bit 0. The sheep lane also counts how many bits it kept. That count is the population count of the inverted mask. After the scan, the sheep field is rotated right by that count, which puts the sheep at the top of the word, and is ORed with the goat field. WIDTH must be a power of two.

The controller has three states. ST_IDLE waits for a request and takes it in (transition IDLE to SCAN on req_valid). ST_SCAN feeds one bit per cycle to both lanes for WIDTH cycles (SCAN to MERGE after the last bit). ST_MERGE registers the rotated and merged word and raises done (MERGE to IDLE, always).

Top module: `sag_separator`

## Requirements
- R1: The low G bits of the result hold the data bits whose mask bit is 1, with the lowest such data bit at result bit 0 and their order kept. G is the number of ones in the mask.
- R2: The high WIDTH-G bits of the result hold the data bits whose mask bit is 0, with the lowest such data bit at result bit G and their order kept.
- R3: A mask of all ones returns the data word unchanged.
- R4: A mask of all zeros returns the data word unchanged, because the rotate amount equals WIDTH and wraps to 0.
- R5: done is high for exactly one cycle, in the cycle that follows the clock edge WIDTH+1 edges after the edge that took in the request.
- R6: req_valid is ignored while busy is high. It does not alter the result in progress, it adds no done pulse and it does not move the timing of that done pulse.
- R7: result changes only on the edge that raises done, and it holds its value until the next done.
- R8: A request seen in ST_IDLE is taken in on that edge. busy is high from the next cycle through the ST_MERGE cycle, which is WIDTH+1 cycles, and it is low in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_data | input | WIDTH | Data word to separate |
| req_mask | input | WIDTH | Selection mask, 1 marks a goat |
| busy | output | 1 | High while a request is being processed |
| done | output | 1 | One-cycle pulse when result is new |
| result | output | WIDTH | Separated word, held between pulses |

## Verification
A request taken in at clock edge k makes busy high after that same edge. The separated word and the done pulse appear together after edge k+WIDTH+1, and done drops again after edge k+WIDTH+2. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the one where it drives the request, expects busy at the first of them, expects done and the new result at exactly the WIDTH+2nd and at no earlier one, and then checks one edge later that done has dropped and the result has not moved. Expected words come from a loop in the bench that walks the mask and places each data bit at its target position directly.

// File: rtl/sag_pkg.sv
package sag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_MERGE = 2'd2
    } sag_state_e;
endpackage

// File: rtl/sag_compress_lane.sv
// Serial compress: each selected input bit is written to the next free slot, starting at bit 0.
module sag_compress_lane #(
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       step,
    input  logic                       bit_in,
    input  logic                       sel,
    output logic [WIDTH-1:0]           packed_bits,
    output logic [$clog2(WIDTH+1)-1:0] kept
);
    localparam int IW = $clog2(WIDTH);
    localparam int CW = $clog2(WIDTH+1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            packed_bits <= '0;
            kept        <= '0;
        end else if (clear) begin
            packed_bits <= '0;
            kept        <= '0;
        end else if (step && sel) begin
            packed_bits[kept[IW-1:0]] <= bit_in;
            kept                      <= kept + CW'(1);
        end
    end
endmodule

// File: rtl/sag_rotmerge.sv
// Rotates the sheep field right by its own bit count and merges it with the goat field.
module sag_rotmerge #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]           sheep,
    input  logic [WIDTH-1:0]           goat,
    input  logic [$clog2(WIDTH+1)-1:0] amount,
    output logic [WIDTH-1:0]           merged
);
    localparam int IW = $clog2(WIDTH);

    logic [IW-1:0]        amt_mod;
    logic [2*WIDTH-1:0]   doubled;

    always_comb begin
        amt_mod = amount[IW-1:0];
        doubled = {sheep, sheep} >> amt_mod;
        merged  = doubled[WIDTH-1:0] | goat;
    end
endmodule

// File: rtl/sag_separator.sv
module sag_separator #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [WIDTH-1:0] req_data,
    input  logic [WIDTH-1:0] req_mask,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    import sag_pkg::*;

    localparam int IW = $clog2(WIDTH);
    localparam int CW = $clog2(WIDTH+1);
    localparam logic [IW-1:0] LAST_STEP = IW'(WIDTH-1);
    localparam int LANES = 2;

    sag_state_e state_q, state_d;

    logic [IW-1:0]    step_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] mask_q;
    logic             lane_clear;
    logic             lane_step;
    logic [WIDTH-1:0] lane_bits [LANES];
    logic [CW-1:0]    lane_kept [LANES];
    logic [WIDTH-1:0] merged_w;

    assign lane_clear = (state_q == ST_IDLE) && req_valid;
    assign lane_step  = (state_q == ST_SCAN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SCAN;
            ST_SCAN:  if (step_q == LAST_STEP) state_d = ST_MERGE;
            ST_MERGE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Operand shift registers and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
            step_q <= '0;
        end else if (lane_clear) begin
            data_q <= req_data;
            mask_q <= req_mask;
            step_q <= '0;
        end else if (lane_step) begin
            data_q <= data_q >> 1;
            mask_q <= mask_q >> 1;
            step_q <= step_q + IW'(1);
        end
    end

    // Lane 0 keeps goats (mask 1), lane 1 keeps sheep (mask 0)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_sel;
        assign lane_sel = (g == 0) ? mask_q[0] : ~mask_q[0];
        sag_compress_lane #(.WIDTH(WIDTH)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear       (lane_clear),
            .step        (lane_step),
            .bit_in      (data_q[0]),
            .sel         (lane_sel),
            .packed_bits (lane_bits[g]),
            .kept        (lane_kept[g])
        );
    end

    sag_rotmerge #(.WIDTH(WIDTH)) u_merge (
        .sheep  (lane_bits[1]),
        .goat   (lane_bits[0]),
        .amount (lane_kept[1]),
        .merged (merged_w)
    );

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= (state_q == ST_MERGE);
            if (state_q == ST_MERGE) result <= merged_w;
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sag_separator_chk.sv
module sag_separator_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result
);
    logic [15:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   busy_run <= '0;
        else if (busy) busy_run <= busy_run + 16'd1;
        else          busy_run <= '0;
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    a_r8_not_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == 16'(WIDTH + 1)));

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
endmodule

bind sag_separator sag_separator_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/sag_separator_tb.sv
`timescale 1ns/1ps
module sag_separator_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [W-1:0] req_data;
    logic [W-1:0] req_mask;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    sag_separator #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_data(req_data), .req_mask(req_mask),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [W-1:0] ref_sag(input logic [W-1:0] d, input logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int lo = 0;
        int hi = 0;
        int g = 0;
        for (int i = 0; i < W; i++) if (m[i]) g++;
        hi = g;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin r[lo] = d[i]; lo++; end
            else      begin r[hi] = d[i]; hi++; end
        end
        return r;
    endfunction

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one request; optionally drives a rival request while busy (R6).
    task automatic run_op(input logic [W-1:0] d, input logic [W-1:0] m, input bit rival);
        logic [W-1:0] exp = ref_sag(d, m);
        logic [W-1:0] low_mask;
        int g = ones(m);
        int seen = 0;
        int early = 0;
        low_mask = (g == W) ? '1 : ((W'(1) << g) - W'(1));
        @(negedge clk);
        req_valid = 1'b1; req_data = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", W'(busy), W'(1));
        for (int j = 1; j <= W + 4; j++) begin
            if (j > 1) @(negedge clk);
            if (rival && j >= 3 && j < 10) begin
                req_valid = 1'b1; req_data = ~d; req_mask = ~m;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin
                if (seen == 0) seen = j; else early++;
                break;
            end
        end
        req_valid = 1'b0;
        check(seen == W + 2, rival ? "R6 done timing with rival" : "R5 done latency",
              W'(seen), W'(W + 2));
        check((result & low_mask) == (exp & low_mask), "R1 goat field", result, exp);
        check((result & ~low_mask) == (exp & ~low_mask), "R2 sheep field", result, exp);
        if (m == '1) check(result == d, "R3 all-ones mask", result, d);
        if (m == '0) check(result == d, "R4 all-zeros mask", result, d);
        check(busy == 1'b0, "R8 idle at done", W'(busy), W'(0));
        @(negedge clk);
        check(done == 1'b0, "R5 single-cycle done", W'(done), W'(0));
        check(result == exp, "R7 result held", result, exp);
        if (rival) check(busy == 1'b0, "R6 rival not taken", W'(busy), W'(0));
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_data = '0; req_mask = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", W'(busy), W'(0));
        check(done == 1'b0, "R5 reset done", W'(done), W'(0));
        check(result == '0, "R7 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(32'hDEAD_BEEF, '1, 0);
        run_op(32'hDEAD_BEEF, '0, 0);
        run_op(32'h8000_0001, 32'h5555_5555, 0);
        run_op(32'hF0F0_1234, 32'hAAAA_AAAA, 0);

        for (int p = 0; p < W; p++) begin
            run_op(next_rand(), W'(1) << p, 0);
            run_op(next_rand(), ~(W'(1) << p), 0);
            run_op(next_rand(), (W'(1) << p) - W'(1), 0);
            run_op(next_rand(), next_rand(), 0);
        end

        run_op(32'h1357_9BDF, 32'h0F0F_00FF, 1);
        run_op(32'hCAFE_F00D, 32'hFFFF_0000, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule